// File: doc/BRIEF.md
# Dual-Channel Hardware Breakpoint Comparator

This block watches every cycle of a CPU bus and raises a break request when an observed access meets the condition programmed into one of its two channels, A or B. A channel condition combines several checks. The address is compared under a mask. An optional 8-bit address-space identifier must match. Three qualifiers select the bus master, the access kind and the direction, and a fourth selects the operand size. Channel B can also compare the data value under its own mask. Channel B can additionally count its matches and only break on the Nth one.

Software programs the channels through a simple register write port. For an instruction-fetch condition, each channel chooses one of two timings. A before-execution break is requested on the cycle after the matching fetch. An after-execution break is held internally and is requested when the instruction-complete strobe arrives. The two channels work independently, and either one can raise the single break request. A sticky flag for each channel records which channel caused a break.

Top module: `dbg_brk_cmp`

## Requirements
- R1: Register addresses are: A base 0, A mask 1, A control 2, B base 3, B mask 4, B control 5, B data 6, B data mask 7, count 8, flags 9. An address bit whose mask bit is 1 is left out of the compare. Base 0x8404 with mask 0xFFF hits 0x8000 and 0x8FFE but not 0x9000. Base 0x8010 with mask 0x006 hits 0x8016 but not 0x8018.
- R2: Control bits [7:0] hold the identifier, and bit 8 enables the identifier compare. When bit 8 is 1, the channel only hits when bus_asid_i equals bits [7:0]. When bit 8 is 0, the identifier is ignored.
- R3: A hit with before timing drives brk_req_o high for exactly one cycle, on the cycle after the matching bus cycle. Before timing means control bit 17 is 0, or the access is a data access.
- R4: A hit on a fetch with control bit 17 set is held internally. brk_req_o stays low until exec_done_i is high, and it is high in that same cycle.
- R5: Control bits [10:9] select the master, bits [12:11] the kind and bits [14:13] the direction. The encodings are 01 = CPU / fetch / read, 10 = other master / data / write, and 11 = either. The encoding 00 in any of these fields disables the channel.
- R6: Control bits [16:15] set the size. The value 00 accepts any size. Otherwise the field must equal bus_size_i, where 01 is byte, 10 is word and 11 is longword.
- R7: When channel B control bit 18 is set, channel B also requires the bits of bus_data_i that are not masked in the data mask register to equal the B data register.
- R8: Register 8 is the count register. Writing it loads the count from bits [15:0] and the enable from bit 31. While the count is enabled, each channel B hit lowers the count by one while it is above 1, and that hit does not break. Once the count is 1 or less, a channel B hit breaks. A count of N therefore passes N-1 hits and breaks on the Nth hit and on every later hit. The count and the enable reset to 0.
- R9: Channels A and B are evaluated separately. A break from either channel drives brk_req_o, and hits on both channels in the same cycle give a single one-cycle request.
- R10: flag_a_o and flag_b_o are sticky and clear to 0 on reset. A flag is set on the clock edge that decides its channel's break. Writing register 9 with bit 0 = 0 clears the A flag, and with bit 1 = 0 clears the B flag. A set on the same edge as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register address |
| wr_data_i | input | 32 | Register write data |
| bus_valid_i | input | 1 | A bus cycle is observed this clock |
| bus_addr_i | input | 32 | Access address |
| bus_asid_i | input | 8 | Current address-space identifier |
| bus_cpu_i | input | 1 | 1 = CPU master, 0 = other master |
| bus_fetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_size_i | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| bus_data_i | input | 32 | Access data value |
| exec_done_i | input | 1 | Instruction-complete strobe |
| brk_req_o | output | 1 | Break request |
| flag_a_o | output | 1 | Sticky channel A break flag |
| flag_b_o | output | 1 | Sticky channel B break flag |

## Verification
The assertions check four behaviours on every cycle. A disabled qualifier never lets a channel hit. A before-timed hit is followed by a request and a flag one cycle later. An after-timed fetch hit always leaves a pending break. The channel B counter only steps down by one and never falls back to zero on its own. The assertions also check that flags stay set until they are cleared and that every request has a cause. The behaviours that only the scenarios can show are end-to-end: the exact address windows that the masks produce, the identifier and size filtering, the data compare, and the fifth-hit break of a count of 5. They also show the delay of an after-timed break across idle cycles, and clearing one flag while the other stays set.

// File: rtl/dbg_brk_pkg.sv
package dbg_brk_pkg;
  localparam int IdW = 8;

  typedef enum logic [1:0] {
    Q_OFF  = 2'b00,
    Q_SEL0 = 2'b01,
    Q_SEL1 = 2'b10,
    Q_ANY  = 2'b11
  } qual_e;

  typedef struct packed {
    logic           data_en;
    logic           after;
    logic [1:0]     size;
    qual_e          dir;
    qual_e          kind;
    qual_e          master;
    logic           asid_en;
    logic [IdW-1:0] asid;
  } chan_cfg_t;

  localparam int CfgW = $bits(chan_cfg_t);

  localparam logic [3:0] REG_A_BASE  = 4'd0;
  localparam logic [3:0] REG_A_MASK  = 4'd1;
  localparam logic [3:0] REG_A_CTRL  = 4'd2;
  localparam logic [3:0] REG_B_BASE  = 4'd3;
  localparam logic [3:0] REG_B_MASK  = 4'd4;
  localparam logic [3:0] REG_B_CTRL  = 4'd5;
  localparam logic [3:0] REG_B_DATA  = 4'd6;
  localparam logic [3:0] REG_B_DMASK = 4'd7;
  localparam logic [3:0] REG_COUNT   = 4'd8;
  localparam logic [3:0] REG_FLAGS   = 4'd9;
endpackage

// File: rtl/brk_chan_cmp.sv
module brk_chan_cmp
  import dbg_brk_pkg::*;
#(
  parameter int AW = 32
) (
  input  chan_cfg_t       cfg_i,
  input  logic [AW-1:0]   base_i,
  input  logic [AW-1:0]   mask_i,
  input  logic            data_ok_i,
  input  logic            bus_valid_i,
  input  logic [AW-1:0]   bus_addr_i,
  input  logic [IdW-1:0]  bus_asid_i,
  input  logic            bus_cpu_i,
  input  logic            bus_fetch_i,
  input  logic            bus_write_i,
  input  logic [1:0]      bus_size_i,
  output logic            hit_o
);
  function automatic logic qual_ok(qual_e q, logic alt);
    return (q == Q_ANY) || (q == Q_SEL0 && !alt) || (q == Q_SEL1 && alt);
  endfunction

  logic addr_ok, asid_ok, size_ok, type_ok;

  assign addr_ok = ((bus_addr_i ^ base_i) & ~mask_i) == '0;
  assign asid_ok = !cfg_i.asid_en || (cfg_i.asid == bus_asid_i);
  assign size_ok = (cfg_i.size == 2'b00) || (cfg_i.size == bus_size_i);
  assign type_ok = qual_ok(cfg_i.master, !bus_cpu_i) &&
                   qual_ok(cfg_i.kind, !bus_fetch_i) &&
                   qual_ok(cfg_i.dir, bus_write_i);

  assign hit_o = bus_valid_i && addr_ok && asid_ok && size_ok && type_ok &&
                 (!cfg_i.data_en || data_ok_i);
endmodule

// File: rtl/brk_occ_cnt.sv
module brk_occ_cnt #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          load_en_i,
  input  logic          hit_i,
  output logic          pass_o,
  output logic          en_o,
  output logic [CW-1:0] cnt_o
);
  localparam logic [CW-1:0] One = {{(CW-1){1'b0}}, 1'b1};

  logic [CW-1:0] cnt_q;
  logic          en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      en_q  <= 1'b0;
    end else if (load_i) begin
      cnt_q <= load_val_i;
      en_q  <= load_en_i;
    end else if (en_q && hit_i && cnt_q > One) begin
      cnt_q <= cnt_q - One;
    end
  end

  assign pass_o = !en_q || (cnt_q <= One);
  assign en_o   = en_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/brk_timing.sv
module brk_timing (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic after_i,
  input  logic fetch_i,
  input  logic done_i,
  output logic now_o,
  output logic late_o,
  output logic pend_o
);
  logic pend_q, defer;

  assign defer  = after_i && fetch_i;
  assign now_o  = hit_i && !defer;
  assign late_o = pend_q && done_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else         pend_q <= (hit_i && defer) || (pend_q && !done_i);
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/dbg_brk_cmp.sv
module dbg_brk_cmp
  import dbg_brk_pkg::*;
#(
  parameter int RW  = 32,
  parameter int AW  = 32,
  parameter int DW  = 32,
  parameter int CW  = 16,
  parameter int RAW = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic [RAW-1:0] wr_addr_i,
  input  logic [RW-1:0]  wr_data_i,
  input  logic           bus_valid_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [IdW-1:0] bus_asid_i,
  input  logic           bus_cpu_i,
  input  logic           bus_fetch_i,
  input  logic           bus_write_i,
  input  logic [1:0]     bus_size_i,
  input  logic [DW-1:0]  bus_data_i,
  input  logic           exec_done_i,
  output logic           brk_req_o,
  output logic           flag_a_o,
  output logic           flag_b_o
);
  localparam int NCH = 2;

  logic [AW-1:0] base_q [NCH];
  logic [AW-1:0] mask_q [NCH];
  chan_cfg_t     cfg_q  [NCH];
  logic [DW-1:0] bdata_q, bdmask_q;

  logic [NCH-1:0] hit, armed, now, late, pend, flag_q, flag_clr;
  logic           b_data_ok, cnt_pass, cnt_en, cnt_wr, fire_q;
  logic [CW-1:0]  cnt_b;

  function automatic logic sel(logic [RAW-1:0] a);
    return wr_en_i && (wr_addr_i == a);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NCH; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
        cfg_q[i]  <= '0;
      end
      bdata_q  <= '0;
      bdmask_q <= '0;
    end else begin
      if (sel(RAW'(REG_A_BASE)))  base_q[0] <= wr_data_i[AW-1:0];
      if (sel(RAW'(REG_A_MASK)))  mask_q[0] <= wr_data_i[AW-1:0];
      if (sel(RAW'(REG_A_CTRL)))  cfg_q[0]  <= chan_cfg_t'(wr_data_i[CfgW-1:0]);
      if (sel(RAW'(REG_B_BASE)))  base_q[1] <= wr_data_i[AW-1:0];
      if (sel(RAW'(REG_B_MASK)))  mask_q[1] <= wr_data_i[AW-1:0];
      if (sel(RAW'(REG_B_CTRL)))  cfg_q[1]  <= chan_cfg_t'(wr_data_i[CfgW-1:0]);
      if (sel(RAW'(REG_B_DATA)))  bdata_q   <= wr_data_i[DW-1:0];
      if (sel(RAW'(REG_B_DMASK))) bdmask_q  <= wr_data_i[DW-1:0];
    end
  end

  assign b_data_ok = ((bus_data_i ^ bdata_q) & ~bdmask_q) == '0;
  assign cnt_wr    = sel(RAW'(REG_COUNT));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    brk_chan_cmp #(.AW(AW)) u_cmp (
      .cfg_i       (cfg_q[c]),
      .base_i      (base_q[c]),
      .mask_i      (mask_q[c]),
      .data_ok_i   ((c == 1) ? b_data_ok : 1'b1),
      .bus_valid_i (bus_valid_i),
      .bus_addr_i  (bus_addr_i),
      .bus_asid_i  (bus_asid_i),
      .bus_cpu_i   (bus_cpu_i),
      .bus_fetch_i (bus_fetch_i),
      .bus_write_i (bus_write_i),
      .bus_size_i  (bus_size_i),
      .hit_o       (hit[c])
    );

    brk_timing u_tim (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (armed[c]),
      .after_i (cfg_q[c].after),
      .fetch_i (bus_fetch_i),
      .done_i  (exec_done_i),
      .now_o   (now[c]),
      .late_o  (late[c]),
      .pend_o  (pend[c])
    );

    assign flag_clr[c] = sel(RAW'(REG_FLAGS)) && !wr_data_i[c];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q[c] <= 1'b0;
      else         flag_q[c] <= now[c] || late[c] || (flag_q[c] && !flag_clr[c]);
    end
  end

  brk_occ_cnt #(.CW(CW)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (cnt_wr),
    .load_val_i (wr_data_i[CW-1:0]),
    .load_en_i  (wr_data_i[RW-1]),
    .hit_i      (hit[1]),
    .pass_o     (cnt_pass),
    .en_o       (cnt_en),
    .cnt_o      (cnt_b)
  );

  assign armed[0] = hit[0];
  assign armed[1] = hit[1] && cnt_pass;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fire_q <= 1'b0;
    else         fire_q <= |now;
  end

  assign brk_req_o = fire_q || (|late);
  assign flag_a_o  = flag_q[0];
  assign flag_b_o  = flag_q[1];
endmodule

// File: rtl/dbg_brk_chk.sv
module dbg_brk_chk
  import dbg_brk_pkg::*;
#(
  parameter int CW  = 16,
  parameter int RAW = 4
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic [RAW-1:0] wr_addr_i,
  input logic           wr_d0_i,
  input logic           bus_fetch_i,
  input logic           exec_done_i,
  input logic           brk_req_o,
  input logic           flag_a_o,
  input logic           hit_a,
  input logic           hit_b,
  input chan_cfg_t      cfg_a,
  input chan_cfg_t      cfg_b,
  input logic           pend_a,
  input logic           fire_q,
  input logic           cnt_en,
  input logic           cnt_wr,
  input logic [CW-1:0]  cnt_b
);
  logic clr_a;
  assign clr_a = wr_en_i && (wr_addr_i == RAW'(REG_FLAGS)) && !wr_d0_i;

  p_off_no_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_a.kind == Q_OFF || cfg_a.master == Q_OFF || cfg_a.dir == Q_OFF) |-> !hit_a);

  p_off_no_hit_b_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_b.kind == Q_OFF || cfg_b.master == Q_OFF || cfg_b.dir == Q_OFF) |-> !hit_b);

  p_before_next_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a && !(cfg_a.after && bus_fetch_i)) |=> (brk_req_o && flag_a_o));

  p_after_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_a && cfg_a.after && bus_fetch_i) |=> pend_a);

  p_count_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_en && hit_b && cnt_b > 1 && !cnt_wr) |=> (cnt_b == $past(cnt_b) - 1'b1));

  p_count_floor_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_b != '0 && !cnt_wr) |=> (cnt_b != '0));

  p_flag_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_a_o && !clr_a) |=> flag_a_o);

  p_req_cause_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_req_o |-> (fire_q || exec_done_i));
endmodule

bind dbg_brk_cmp dbg_brk_chk #(.CW(CW), .RAW(RAW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_d0_i     (wr_data_i[0]),
  .bus_fetch_i (bus_fetch_i),
  .exec_done_i (exec_done_i),
  .brk_req_o   (brk_req_o),
  .flag_a_o    (flag_a_o),
  .hit_a       (hit[0]),
  .hit_b       (hit[1]),
  .cfg_a       (cfg_q[0]),
  .cfg_b       (cfg_q[1]),
  .pend_a      (pend[0]),
  .fire_q      (fire_q),
  .cnt_en      (cnt_en),
  .cnt_wr      (cnt_wr),
  .cnt_b       (cnt_b)
);

// File: tb/dbg_brk_cmp_test.sv
`timescale 1ns/1ps
module dbg_brk_cmp_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        bv = 1'b0, bcpu = 1'b1, bfetch = 1'b1, bwrite = 1'b0, done = 1'b0;
  logic [31:0] baddr = '0, bdata = '0;
  logic [7:0]  basid = '0;
  logic [1:0]  bsize = 2'b11;
  logic        brk, fa, fb;

  int checks = 0, fails = 0;
  string cur = "R10";

  always #10 clk = ~clk;

  dbg_brk_cmp uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .bus_valid_i(bv), .bus_addr_i(baddr), .bus_asid_i(basid), .bus_cpu_i(bcpu),
    .bus_fetch_i(bfetch), .bus_write_i(bwrite), .bus_size_i(bsize), .bus_data_i(bdata),
    .exec_done_i(done), .brk_req_o(brk), .flag_a_o(fa), .flag_b_o(fb)
  );

  // reference model state
  logic [31:0] m_base[2], m_mask[2], m_ctl[2], m_bd, m_bdm;
  int  m_cnt;
  bit  m_cen, m_fire, m_pa, m_pb, m_fa, m_fb;

  function automatic bit q_ok(logic [1:0] q, bit alt);
    if (q == 2'b11) return 1;
    if (q == 2'b01) return !alt;
    if (q == 2'b10) return alt;
    return 0;
  endfunction

  function automatic bit m_hit(int c);
    logic [31:0] k = m_ctl[c];
    if (!bv) return 0;
    if (((baddr ^ m_base[c]) & ~m_mask[c]) != 0) return 0;
    if (k[8] && k[7:0] != basid) return 0;
    if (k[16:15] != 0 && k[16:15] != bsize) return 0;
    if (!q_ok(k[10:9], !bcpu) || !q_ok(k[12:11], !bfetch) || !q_ok(k[14:13], bwrite)) return 0;
    if (c == 1 && k[18] && ((bdata ^ m_bd) & ~m_bdm) != 0) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit ha, hb, na, nb, la, lb, aa, ab, ca, cb;
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin m_base[i] = 0; m_mask[i] = 0; m_ctl[i] = 0; end
      m_bd = 0; m_bdm = 0; m_cnt = 0; m_cen = 0;
      m_fire = 0; m_pa = 0; m_pb = 0; m_fa = 0; m_fb = 0;
    end else begin
      ha = m_hit(0);
      hb = m_hit(1);
      aa = m_ctl[0][17] && bfetch;
      ab = m_ctl[1][17] && bfetch;
      na = ha && !aa;
      nb = hb && (!m_cen || m_cnt <= 1) && !ab;
      la = m_pa && done;
      lb = m_pb && done;
      m_fire = na || nb;
      m_pa = (ha && aa) || (m_pa && !done);
      m_pb = (hb && (!m_cen || m_cnt <= 1) && ab) || (m_pb && !done);
      ca = wr_en && wr_addr == 9 && !wr_data[0];
      cb = wr_en && wr_addr == 9 && !wr_data[1];
      m_fa = na || la || (m_fa && !ca);
      m_fb = nb || lb || (m_fb && !cb);
      if (wr_en && wr_addr == 8) begin m_cnt = wr_data[15:0]; m_cen = wr_data[31]; end
      else if (m_cen && hb && m_cnt > 1) m_cnt--;
      if (wr_en) case (wr_addr)
        0: m_base[0] = wr_data; 1: m_mask[0] = wr_data; 2: m_ctl[0] = wr_data;
        3: m_base[1] = wr_data; 4: m_mask[1] = wr_data; 5: m_ctl[1] = wr_data;
        6: m_bd = wr_data;      7: m_bdm = wr_data;
        default: ;
      endcase
    end
  end

  always @(negedge clk) begin
    bit er;
    #2;
    er = m_fire || ((m_pa || m_pb) && done);
    checks++;
    if (brk !== er || fa !== m_fa || fb !== m_fb) begin
      fails++;
      $display("FAIL %s: brk/fa/fb actual %b%b%b expected %b%b%b at %0t",
               cur, brk, fa, fb, er, m_fa, m_fb, $time);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic acc(input logic [31:0] a, input logic [7:0] id, input bit cpu, input bit f,
                     input bit w, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); bv = 1; baddr = a; basid = id; bcpu = cpu; bfetch = f;
    bwrite = w; bsize = sz; bdata = d;
    @(negedge clk); bv = 0;
  endtask

  task automatic fetch(input logic [31:0] a);
    acc(a, 8'h00, 1, 1, 0, 2'b11, 32'h0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_done();
    @(negedge clk); done = 1;
    @(negedge clk); done = 0;
  endtask

  // control word: cpu, fetch, read, any size
  localparam logic [31:0] CtlFetch = (32'd1 << 9) | (32'd1 << 11) | (32'd1 << 13);

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cur = "R10";
    idle(3);
    checks++;
    if (brk !== 0 || fa !== 0 || fb !== 0) begin
      fails++; $display("FAIL R10 reset outputs actual %b%b%b expected 000", brk, fa, fb);
    end
    rst_n = 1;
    idle(2);

    cur = "R1";
    wr(0, 32'h8404); wr(1, 32'hFFF); wr(2, CtlFetch);
    fetch(32'h8000); fetch(32'h8FFE); fetch(32'h9000); fetch(32'h7FFE);
    wr(9, 0);
    wr(3, 32'h8010); wr(4, 32'h006); wr(5, CtlFetch);
    fetch(32'h8016); fetch(32'h8018); fetch(32'h8012);
    wr(9, 0); wr(5, 0);

    cur = "R2";
    wr(2, CtlFetch | (32'd1 << 8) | 32'h80);
    acc(32'h8100, 8'h80, 1, 1, 0, 2'b11, 0);
    acc(32'h8100, 8'h81, 1, 1, 0, 2'b11, 0);
    wr(2, CtlFetch | 32'h80);
    acc(32'h8100, 8'h81, 1, 1, 0, 2'b11, 0);
    wr(9, 0);

    cur = "R6";
    wr(2, CtlFetch | (32'd3 << 15));
    acc(32'h8100, 0, 1, 1, 0, 2'b11, 0);
    acc(32'h8100, 0, 1, 1, 0, 2'b10, 0);
    acc(32'h8100, 0, 1, 1, 0, 2'b01, 0);
    wr(9, 0);

    cur = "R5";
    wr(2, (32'd1 << 9) | (32'd1 << 13));
    fetch(32'h8100);
    wr(2, (32'd1 << 9) | (32'd1 << 11) | (32'd2 << 13));
    fetch(32'h8100);
    acc(32'h8100, 0, 1, 1, 1, 2'b11, 0);
    wr(2, (32'd2 << 9) | (32'd3 << 11) | (32'd3 << 13));
    acc(32'h8100, 0, 1, 0, 1, 2'b01, 0);
    acc(32'h8100, 0, 0, 0, 1, 2'b01, 0);
    wr(2, (32'd3 << 9) | (32'd2 << 11) | (32'd3 << 13));
    acc(32'h8100, 0, 1, 0, 0, 2'b10, 0);
    fetch(32'h8100);
    wr(9, 0);

    cur = "R3";
    wr(2, CtlFetch);
    fetch(32'h8200);
    fetch(32'h8202);
    wr(9, 0);

    cur = "R4";
    wr(2, CtlFetch | (32'd1 << 17));
    fetch(32'h8400);
    idle(3);
    pulse_done();
    pulse_done();
    wr(2, (32'd1 << 9) | (32'd2 << 11) | (32'd1 << 13) | (32'd1 << 17));
    acc(32'h8400, 0, 1, 0, 0, 2'b11, 0);
    wr(9, 0); wr(2, 0);

    cur = "R7";
    wr(3, 32'h1000); wr(4, 0); wr(6, 32'h1234_5678); wr(7, 32'hFF);
    wr(5, CtlFetch | (32'd1 << 18));
    acc(32'h1000, 0, 1, 1, 0, 2'b11, 32'h1234_56AA);
    acc(32'h1000, 0, 1, 1, 0, 2'b11, 32'h1234_5778);
    wr(5, CtlFetch);
    acc(32'h1000, 0, 1, 1, 0, 2'b11, 32'hDEAD_BEEF);
    wr(9, 0);

    cur = "R8";
    wr(8, 32'h8000_0005);
    for (int i = 0; i < 7; i++) fetch(32'h1000);
    wr(9, 0);
    wr(8, 32'h8000_0002);
    fetch(32'h1000); fetch(32'h1000);
    wr(8, 32'h0000_0000);
    fetch(32'h1000);
    wr(9, 0);

    cur = "R9";
    wr(0, 32'h1000); wr(1, 0); wr(2, CtlFetch);
    fetch(32'h1000);
    idle(2);

    cur = "R10";
    wr(9, 32'h2);
    idle(2);
    fetch(32'h1000);
    wr(9, 32'h1);
    wr(9, 32'h3);
    idle(2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule